// File: doc/BRIEF.md
# Epoch Result History with Operand Rewrite

This block keeps, for each architectural register, a short record of the value that register held when each recent epoch closed. An epoch is the span of one instruction slice. While an epoch runs, results written to a register are held as that register's pending value, and a later write to the same register replaces an earlier one. When the epoch-advance strobe fires, every register's record moves back by one entry. The newest entry then takes the pending value if the register was written during that epoch, or the previous newest value if it was not. The oldest entry is dropped.

When a slice is replayed after a long-latency miss, each of its instructions is presented on the read port together with an epoch age. The source register is taken from a field of the instruction itself. If the instruction is flagged as an exposed read, the block returns it rewritten so that the register source becomes an immediate holding the recorded value. It also reports that the physical register which held that live-in may be freed. Ages older than the retained history raise an error flag instead.

Top module: `epoch_result_history`

## Requirements
- R1: After reset, every history entry reads as zero, no register has a pending write, and `rsp_valid`, `rsp_err` and `free_valid` are low.
- R2: A request with `rd_en` high is answered on the following cycle with `rsp_valid` high. `rsp_value` is the value of the register in instruction bits [19:17] at the requested age. Age 0 means the epoch still in progress: the pending value if one exists, otherwise the newest entry. Age k, for 1 ≤ k ≤ DEPTH, means the value at the close of the k-th most recently closed epoch.
- R3: On an advance, a register with no write in the closing epoch takes its previous newest value as the new newest entry.
- R4: On an advance, a register written in the closing epoch takes the last value written to it as the new newest entry. A write in the same cycle as the advance belongs to the closing epoch.
- R5: Each advance moves the entry at age k to age k+1, and the entry at age DEPTH is discarded.
- R6: A write and an age-0 read of the same register in the same cycle return the written data.
- R7: Instruction layout (default widths): imm in [15:0], imm-select in [16], source register in [19:17], destination in [22:20], opcode in [30:23]. For an exposed read within range, the returned instruction has imm set to the value, imm-select set to 1 and the source field set to 0, with every other field unchanged. A read that is not exposed returns the instruction unchanged.
- R8: For an exposed read within range, `free_valid` is high with the response and `free_phys` equals the `rd_phys` given with the request. Otherwise `free_valid` is low.
- R9: An age greater than DEPTH gives `rsp_err` high, `rsp_value` zero, the instruction unchanged and no free.
- R10: A write or advance never changes any register's history other than in the ways set out in R3 to R5. In particular, a write to one register leaves the values read from every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Result write valid in current epoch |
| wr_reg | input | RW | Architectural register written |
| wr_data | input | DW | Value read from the mapped destination physical register |
| adv | input | 1 | Epoch-advance strobe |
| rd_en | input | 1 | Rewrite request valid |
| rd_insn | input | IW | Instruction; its source field selects the register |
| rd_exposed | input | 1 | Instruction is an exposed read |
| rd_age | input | AGW | Epoch age, 0 = current epoch |
| rd_phys | input | PW | Physical register holding the live-in |
| rsp_valid | output | 1 | Response valid |
| rsp_value | output | DW | Recorded register value |
| rsp_insn | output | IW | Rewritten or passed-through instruction |
| rsp_err | output | 1 | Requested age beyond retained history |
| free_valid | output | 1 | Live-in physical register may be freed |
| free_phys | output | PW | Physical register to free |

## Verification
The assertions assume that `rd_insn` names a register below NREG and that reset is held for at least one clock edge. With those inputs, the shift, hold and rewrite properties follow from the ports alone. The stimulus only uses register numbers 0 to 7, holds reset for several cycles, and raises `adv` only in cycles whose expected effect is tracked by the bench's own history model. It drives simultaneous write, advance and read only in the directed cases that exist for that purpose.

// File: rtl/epoch_result_history.sv
module epoch_result_history #(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int PW    = 6,
  parameter int OPW   = 8,
  localparam int RW   = $clog2(NREG),
  localparam int AGW  = $clog2(DEPTH + 1) + 1,
  localparam int IW   = OPW + 2 * RW + 1 + DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RW-1:0]  wr_reg,
  input  logic [DW-1:0]  wr_data,
  input  logic           adv,
  input  logic           rd_en,
  input  logic [IW-1:0]  rd_insn,
  input  logic           rd_exposed,
  input  logic [AGW-1:0] rd_age,
  input  logic [PW-1:0]  rd_phys,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_value,
  output logic [IW-1:0]  rsp_insn,
  output logic           rsp_err,
  output logic           free_valid,
  output logic [PW-1:0]  free_phys
);
  localparam int HW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SRC_LO = DW + 1;

  logic [DW-1:0] hist [NREG][DEPTH];
  logic [DW-1:0] pend_val [NREG];
  logic [NREG-1:0] pend_v;
  logic [NREG-1:0] wr_hit;

  assign wr_hit = wr_en ? (NREG'(1) << wr_reg) : '0;

  logic [RW-1:0]  rreg;
  logic [AGW-1:0] age_m1;
  logic [HW-1:0]  hidx;
  logic           age_ok;
  logic [DW-1:0]  cur_val, rd_val;
  logic [IW-1:0]  new_insn;

  assign rreg   = rd_insn[SRC_LO +: RW];
  assign age_ok = rd_age <= AGW'(DEPTH);
  assign age_m1 = rd_age - 1'b1;
  assign hidx   = age_m1[HW-1:0];
  assign cur_val = wr_hit[rreg] ? wr_data : (pend_v[rreg] ? pend_val[rreg] : hist[rreg][0]);
  assign rd_val  = (rd_age == '0) ? cur_val : hist[rreg][hidx];

  always_comb begin
    new_insn = rd_insn;
    if (rd_exposed && age_ok) begin
      new_insn[DW-1:0]         = rd_val;
      new_insn[DW]             = 1'b1;
      new_insn[SRC_LO +: RW]   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        for (int k = 0; k < DEPTH; k++) hist[r][k] <= '0;
        pend_val[r] <= '0;
      end
      pend_v     <= '0;
      rsp_valid  <= 1'b0;
      rsp_value  <= '0;
      rsp_insn   <= '0;
      rsp_err    <= 1'b0;
      free_valid <= 1'b0;
      free_phys  <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (adv) begin
          hist[r][0] <= wr_hit[r] ? wr_data : (pend_v[r] ? pend_val[r] : hist[r][0]);
          for (int k = 1; k < DEPTH; k++) hist[r][k] <= hist[r][k-1];
          pend_v[r] <= 1'b0;
        end else if (wr_hit[r]) begin
          pend_v[r]   <= 1'b1;
          pend_val[r] <= wr_data;
        end
      end
      rsp_valid  <= rd_en;
      rsp_err    <= rd_en && !age_ok;
      rsp_value  <= (rd_en && age_ok) ? rd_val : '0;
      rsp_insn   <= new_insn;
      free_valid <= rd_en && rd_exposed && age_ok;
      free_phys  <= rd_phys;
    end
  end

  // R8
  free_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> rsp_valid && !rsp_err);

  // R9
  err_nofree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !free_valid && rsp_value == '0);

  // R7
  imm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> rsp_insn[DW] && rsp_insn[DW-1:0] == rsp_value && rsp_insn[SRC_LO +: RW] == '0);

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_err && !free_valid);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (DEPTH > 1) begin : g_deep
      // R5
      shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> hist[g][DEPTH-1] == $past(hist[g][DEPTH-2]));
    end
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(hist[g][0]));
    // R3
    copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !pend_v[g] && !wr_hit[g]) |=> hist[g][0] == $past(hist[g][0]));
  end
endmodule

// File: tb/epoch_result_history_test.sv
module epoch_result_history_test;
  localparam int NREG = 8, DW = 16, DEPTH = 8, PW = 6, OPW = 8;
  localparam int RW = $clog2(NREG), AGW = $clog2(DEPTH + 1) + 1;
  localparam int IW = OPW + 2 * RW + 1 + DW;
  localparam int NV = 18;
  // vector: kind[26:25] (0 write,1 advance,2 read) reg[24:22] data[21:6] age[5:1] exposed[0]
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 3'd1, 16'h1111, 5'd0, 1'b0},
    {2'd0, 3'd1, 16'h1122, 5'd0, 1'b0},
    {2'd2, 3'd1, 16'h0000, 5'd0, 1'b1},
    {2'd0, 3'd2, 16'h2222, 5'd0, 1'b0},
    {2'd1, 3'd0, 16'h0000, 5'd0, 1'b0},
    {2'd2, 3'd1, 16'h0000, 5'd1, 1'b1},
    {2'd2, 3'd1, 16'h0000, 5'd0, 1'b1},
    {2'd2, 3'd3, 16'h0000, 5'd1, 1'b1},
    {2'd1, 3'd0, 16'h0000, 5'd0, 1'b0},
    {2'd2, 3'd1, 16'h0000, 5'd2, 1'b1},
    {2'd2, 3'd2, 16'h0000, 5'd2, 1'b1},
    {2'd0, 3'd1, 16'h3333, 5'd0, 1'b0},
    {2'd1, 3'd0, 16'h0000, 5'd0, 1'b0},
    {2'd2, 3'd1, 16'h0000, 5'd1, 1'b1},
    {2'd2, 3'd1, 16'h0000, 5'd2, 1'b1},
    {2'd2, 3'd2, 16'h0000, 5'd1, 1'b1},
    {2'd2, 3'd1, 16'h0000, 5'd0, 1'b0},
    {2'd2, 3'd0, 16'h0000, 5'd3, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, adv = 0, rd_en = 0, rd_exposed = 0;
  logic [RW-1:0] wr_reg = '0;
  logic [DW-1:0] wr_data = '0;
  logic [IW-1:0] rd_insn = '0;
  logic [AGW-1:0] rd_age = '0;
  logic [PW-1:0] rd_phys = '0;
  logic rsp_valid, rsp_err, free_valid;
  logic [DW-1:0] rsp_value;
  logic [IW-1:0] rsp_insn;
  logic [PW-1:0] free_phys;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] m_h [NREG][DEPTH];
  logic [DW-1:0] m_pd [NREG];
  logic [NREG-1:0] m_pv;

  always #4 clk = ~clk;

  epoch_result_history #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH), .PW(PW), .OPW(OPW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data), .adv(adv),
    .rd_en(rd_en), .rd_insn(rd_insn), .rd_exposed(rd_exposed), .rd_age(rd_age), .rd_phys(rd_phys),
    .rsp_valid(rsp_valid), .rsp_value(rsp_value), .rsp_insn(rsp_insn), .rsp_err(rsp_err),
    .free_valid(free_valid), .free_phys(free_phys));

  task automatic cyc; @(posedge clk); @(negedge clk); endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mk_insn(input logic [RW-1:0] src);
    return {8'hA5, 3'd6, src, 1'b0, 16'h0000};
  endfunction

  function automatic logic [DW-1:0] m_val(input int r, input int age);
    if (age == 0) return m_pv[r] ? m_pd[r] : m_h[r][0];
    return m_h[r][age-1];
  endfunction

  task automatic m_write(input int r, input logic [DW-1:0] d);
    m_pv[r] = 1'b1; m_pd[r] = d;
  endtask

  task automatic m_adv;
    for (int r = 0; r < NREG; r++) begin
      for (int k = DEPTH - 1; k > 0; k--) m_h[r][k] = m_h[r][k-1];
      if (m_pv[r]) m_h[r][0] = m_pd[r];
    end
    m_pv = '0;
  endtask

  task automatic do_write(input int r, input logic [DW-1:0] d, input bit with_adv);
    wr_en = 1; wr_reg = RW'(r); wr_data = d; adv = with_adv;
    cyc();
    wr_en = 0; adv = 0;
    m_write(r, d);
    if (with_adv) m_adv();
  endtask

  task automatic do_adv;
    adv = 1; cyc(); adv = 0; m_adv();
  endtask

  task automatic do_read(input string tag, input int r, input int age, input bit expo,
                         input logic [PW-1:0] ph, input bit byp, input logic [DW-1:0] bd);
    logic [IW-1:0] ins, ei;
    logic [DW-1:0] ev;
    bit ok, ef;
    if (byp) m_write(r, bd);
    ok = age <= DEPTH;
    ev = ok ? m_val(r, age) : '0;
    ins = mk_insn(RW'(r));
    ei = ins;
    if (expo && ok) ei = {8'hA5, 3'd6, {RW{1'b0}}, 1'b1, ev};
    ef = expo && ok;
    rd_en = 1; rd_insn = ins; rd_exposed = expo; rd_age = AGW'(age); rd_phys = ph;
    if (byp) begin wr_en = 1; wr_reg = RW'(r); wr_data = bd; end
    cyc();
    rd_en = 0; wr_en = 0;
    check(tag, {rsp_valid, rsp_err, rsp_value}, {1'b1, !ok, ev});
    check({tag, " insn"}, 64'(rsp_insn), 64'(ei));
    check({tag, " free"}, {free_valid, (ef ? free_phys : 6'd0)}, {ef, (ef ? ph : 6'd0)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin
      m_pd[r] = '0;
      for (int k = 0; k < DEPTH; k++) m_h[r][k] = '0;
    end
    m_pv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 idle", {rsp_valid, rsp_err, free_valid}, 3'b000);
    do_read("R1 reset hist", 5, 3, 1, 6'd9, 0, '0);
    do_read("R1 no pending", 5, 0, 1, 6'd9, 0, '0);

    // R2 table-driven sequence (also covers R3, R4 last-wins)
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      case (v[26:25])
        2'd0: do_write(int'(v[24:22]), v[21:6], 0);
        2'd1: do_adv();
        default: do_read("R2 table", int'(v[24:22]), int'(v[5:1]), v[0], 6'(i), 0, '0);
      endcase
    end

    // R4 write coinciding with advance belongs to closing epoch
    do_write(5, 16'h5555, 0);
    do_write(5, 16'h5A5A, 1);
    do_read("R4 adv write", 5, 1, 1, 6'd1, 0, '0);
    do_read("R4 new epoch", 5, 0, 1, 6'd1, 0, '0);

    // R3 copy forward without write
    do_write(6, 16'h6666, 1);
    do_adv();
    do_read("R3 copy a1", 6, 1, 1, 6'd2, 0, '0);
    do_read("R3 copy a2", 6, 2, 1, 6'd2, 0, '0);

    // R5 fill history and check every age, then discard oldest
    for (int i = 0; i < DEPTH; i++) do_write(4, 16'h4000 + 16'(i), 1);
    for (int a = 1; a <= DEPTH; a++) do_read("R5 age", 4, a, 1, 6'(a), 0, '0);
    do_adv();
    do_read("R5 oldest dropped", 4, DEPTH, 1, 6'd3, 0, '0);
    do_read("R5 shifted", 4, 2, 1, 6'd3, 0, '0);

    // R6 bypass of same-cycle write
    do_read("R6 bypass", 7, 0, 1, 6'd11, 1, 16'hBEEF);
    do_read("R6 after", 7, 0, 1, 6'd11, 0, '0);

    // R7 non-exposed passes unchanged; R8 free tag
    do_read("R7 passthru", 4, 1, 0, 6'd20, 0, '0);
    do_read("R8 free tag", 4, 1, 1, 6'd63, 0, '0);

    // R9 age limits
    do_read("R9 max age", 4, DEPTH, 1, 6'd5, 0, '0);
    do_read("R9 too old", 4, DEPTH + 1, 1, 6'd5, 0, '0);
    do_read("R9 way old", 4, 31, 1, 6'd5, 0, '0);

    // R10 independence of registers
    do_write(1, 16'h9999, 0);
    do_read("R10 other reg", 0, 0, 1, 6'd7, 0, '0);
    do_read("R10 other hist", 2, 3, 1, 6'd7, 0, '0);
    do_read("R10 written reg", 1, 0, 1, 6'd7, 0, '0);

    summary();
  end
endmodule